// File: doc/BRIEF.md
# Coprocessor Serial Boot Loader

This block lets a host processor fill the first bytes of a coprocessor's program RAM before the coprocessor starts running. The host has only a one-byte command mailbox to work with. Each write to the mailbox carries a toggle bit, a data bit and a reset-request bit. A bit is taken only when the toggle differs from the previous command. Taken bits are packed into bytes, most significant bit first. Each finished byte is written to the next RAM address through a simple byte write port.

While loading, the host paces itself on a busy flag in the status byte it reads back. The block sets this flag for every accepted bit and clears it by itself after a fixed delay. When the last byte of the image has been written, the block releases the coprocessor from reset. After that, any further toggles are ignored until the host asks for a reset again.

The same pair of mailboxes also carries traffic once the coprocessor is running. Every host command raises the coprocessor's fast-interrupt line, and the coprocessor can read the command byte. A coprocessor write to the reverse mailbox drops the interrupt line and replaces the status byte the host sees.

Top module: `copro_boot_loader`

## Requirements
- R1: A host command with bit 1 set drives `coproReset` high on the next cycle and restarts the RAM address at 0. The bit count and the partial byte are kept.
- R2: A host command adds a data bit only when its bit 7 differs from bit 7 of the previous host command. A command without a toggle adds no bit, writes no RAM and does not touch busy bit 0 of `hostStatus`.
- R3: An accepted command contributes its bit 0, and bits fill the byte MSB first. On the 8th bit, `ramWrEn` pulses for one cycle with the current address and the assembled byte. The address then increments.
- R4: The write of the last image byte (address IMAGE_BYTES-1) deasserts `coproReset` in the same cycle. After that, toggling commands write nothing, set no busy bit and leave `coproReset` low.
- R5: Each accepted bit that leaves the address below IMAGE_BYTES sets bit 0 of `hostStatus` and leaves bits 7..1 unchanged. Bit 0 clears after BUSY_US microseconds, which is 750 cycles at the default 50 MHz.
- R6: Every host command raises `fastIrq` on the next cycle, and `coproCmd` shows the written byte.
- R7: A coprocessor write lowers `fastIrq` and replaces `hostStatus` with the written byte. If a host command arrives in the same cycle, the host command wins on `fastIrq`.
- R8: After reset, `coproCmd` and `hostStatus` are 0, `fastIrq` is low, `coproReset` is high, no RAM write is pending, and loading starts at address 0.
- R9: An accepted bit that arrives while the busy flag is set restarts the full busy delay.
- R10: A reset-request command whose bit 7 toggles also delivers its bit 0 as a data bit, counted against address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host command write strobe |
| hostWrData | input | 8 | Host command byte: bit 7 toggle, bit 1 reset request, bit 0 data |
| hostStatus | output | 8 | Status byte read by the host; bit 0 is the busy flag |
| coproWrEn | input | 1 | Coprocessor write strobe to the reverse mailbox |
| coproWrData | input | 8 | Byte written by the coprocessor |
| coproCmd | output | 8 | Last host command byte, read by the coprocessor |
| fastIrq | output | 1 | Fast-interrupt request to the coprocessor |
| coproReset | output | 1 | Coprocessor reset, active high |
| ramWrEn | output | 1 | RAM byte write strobe |
| ramWrAddr | output | 8 | RAM byte address |
| ramWrData | output | 8 | RAM byte data |

## Verification
A wrong bit count or a corrupted partial byte shows up at the next RAM write strobe, which comes eight accepted commands later, as a wrong data byte. A slipped address counter shows up at every following write. It also moves the moment `coproReset` falls away from the write to the final address. A broken toggle comparison either inserts or drops a bit. Because of that, every later byte in the image comes out shifted, which the scoreboard catches on the first write after the fault. A wrong busy timer can only be seen on `hostStatus` bit 0, so the delay is checked at both edges of its window, one cycle apart.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
  // Host command byte layout (the host software depends on these positions)
  localparam int TOGGLE_POS = 7;
  localparam int RESET_POS  = 1;
  localparam int DATA_POS   = 0;
  // Busy flag position inside the host-readable status byte
  localparam int BUSY_POS   = 0;

  typedef struct packed {
    logic postCmd;      // host command byte arrives
    logic forceReset;   // host asks for coprocessor reset
    logic takeBit;      // command carries an accepted data bit
    logic commitByte;   // accepted bit completes a byte
    logic finishImage;  // completed byte is the last of the image
    logic armBusy;      // start or restart the busy window
  } ctlStrobe_t;
endpackage

// File: rtl/boot_ld_ctrl.sv
module boot_ld_ctrl
  import boot_ld_pkg::*;
#(
  parameter int IMAGE_BYTES = 256,
  parameter int MBOX_W      = 8,
  localparam int ADDR_W     = $clog2(IMAGE_BYTES) + 1,
  localparam int CNT_W      = $clog2(MBOX_W)
) (
  input  logic              hostWrEn,
  input  logic              toggleIn,
  input  logic              resetReq,
  input  logic              prevToggle,
  input  logic [ADDR_W-1:0] addrCnt,
  input  logic [CNT_W-1:0]  bitCnt,
  output ctlStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] FULL_ADDR = ADDR_W'(IMAGE_BYTES);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMAGE_BYTES - 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(MBOX_W - 1);

  logic [ADDR_W-1:0] effAddr;
  logic roomLeft;

  always_comb begin
    strobe            = '0;
    strobe.postCmd    = hostWrEn;
    strobe.forceReset = hostWrEn & resetReq;
    effAddr           = strobe.forceReset ? '0 : addrCnt;
    roomLeft          = effAddr < FULL_ADDR;
    strobe.takeBit    = hostWrEn & (toggleIn ^ prevToggle) & roomLeft;
    strobe.commitByte = strobe.takeBit & (bitCnt == LAST_BIT);
    strobe.finishImage = strobe.commitByte & (effAddr == LAST_ADDR);
    strobe.armBusy    = strobe.takeBit & ~strobe.finishImage;
  end
endmodule

// File: rtl/boot_ld_datapath.sv
module boot_ld_datapath
  import boot_ld_pkg::*;
#(
  parameter int IMAGE_BYTES = 256,
  parameter int MBOX_W      = 8,
  parameter int BUSY_CYCLES = 750,
  localparam int ADDR_W     = $clog2(IMAGE_BYTES) + 1,
  localparam int RAM_AW     = $clog2(IMAGE_BYTES),
  localparam int CNT_W      = $clog2(MBOX_W),
  localparam int TMR_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [MBOX_W-1:0] hostWrData,
  input  logic              coproWrEn,
  input  logic [MBOX_W-1:0] coproWrData,
  output logic [ADDR_W-1:0] addrCnt,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [MBOX_W-1:0] coproCmd,
  output logic [MBOX_W-1:0] hostStatus,
  output logic              fastIrq,
  output logic              coproReset,
  output logic              ramWrEn,
  output logic [RAM_AW-1:0] ramWrAddr,
  output logic [MBOX_W-1:0] ramWrData
);
  logic [MBOX_W-1:0] shiftAcc;
  logic [TMR_W-1:0]  busyTimer;
  logic [ADDR_W-1:0] baseAddr;
  logic [MBOX_W-1:0] fullByte;
  logic              busyExpire;
  logic [MBOX_W-1:0] statusNext;

  assign baseAddr   = strobe.forceReset ? '0 : addrCnt;
  assign fullByte   = {shiftAcc[MBOX_W-2:0], hostWrData[DATA_POS]};
  assign busyExpire = (busyTimer == TMR_W'(1)) & ~strobe.armBusy;

  always_comb begin
    statusNext = hostStatus;
    if (coproWrEn)      statusNext = coproWrData;
    if (busyExpire)     statusNext[BUSY_POS] = 1'b0;
    if (strobe.armBusy) statusNext[BUSY_POS] = 1'b1;
  end

  // Mailboxes and interrupt line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coproCmd   <= '0;
      hostStatus <= '0;
      fastIrq    <= 1'b0;
    end else begin
      if (strobe.postCmd) coproCmd <= hostWrData;
      hostStatus <= statusNext;
      if (strobe.postCmd)  fastIrq <= 1'b1;
      else if (coproWrEn)  fastIrq <= 1'b0;
    end
  end

  // Busy window timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busyTimer <= '0;
    else if (strobe.armBusy)         busyTimer <= TMR_W'(BUSY_CYCLES);
    else if (busyTimer != '0)        busyTimer <= busyTimer - TMR_W'(1);
  end

  // Bit assembly and address sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftAcc   <= '0;
      bitCnt     <= '0;
      addrCnt    <= '0;
      coproReset <= 1'b1;
      ramWrEn    <= 1'b0;
      ramWrAddr  <= '0;
      ramWrData  <= '0;
    end else begin
      ramWrEn <= strobe.commitByte;
      if (strobe.commitByte) begin
        ramWrAddr <= baseAddr[RAM_AW-1:0];
        ramWrData <= fullByte;
        shiftAcc  <= '0;
        bitCnt    <= '0;
        addrCnt   <= baseAddr + ADDR_W'(1);
      end else begin
        if (strobe.takeBit) begin
          shiftAcc <= fullByte;
          bitCnt   <= bitCnt + CNT_W'(1);
        end
        if (strobe.forceReset) addrCnt <= '0;
      end
      if (strobe.finishImage)     coproReset <= 1'b0;
      else if (strobe.forceReset) coproReset <= 1'b1;
    end
  end
endmodule

// File: rtl/copro_boot_loader.sv
module copro_boot_loader
  import boot_ld_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BUSY_US     = 15,
  parameter int IMAGE_BYTES = 256,
  localparam int MBOX_W     = 8,
  localparam int RAM_AW     = $clog2(IMAGE_BYTES),
  localparam int ADDR_W     = RAM_AW + 1,
  localparam int CNT_W      = $clog2(MBOX_W),
  localparam int BUSY_CYCLES = (CLK_HZ / 1_000_000) * BUSY_US
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic [MBOX_W-1:0] hostWrData,
  output logic [MBOX_W-1:0] hostStatus,
  input  logic              coproWrEn,
  input  logic [MBOX_W-1:0] coproWrData,
  output logic [MBOX_W-1:0] coproCmd,
  output logic              fastIrq,
  output logic              coproReset,
  output logic              ramWrEn,
  output logic [RAM_AW-1:0] ramWrAddr,
  output logic [MBOX_W-1:0] ramWrData
);
  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] addrCnt;
  logic [CNT_W-1:0]  bitCnt;

  boot_ld_ctrl #(.IMAGE_BYTES(IMAGE_BYTES), .MBOX_W(MBOX_W)) u_ctrl (
    .hostWrEn   (hostWrEn),
    .toggleIn   (hostWrData[TOGGLE_POS]),
    .resetReq   (hostWrData[RESET_POS]),
    .prevToggle (coproCmd[TOGGLE_POS]),
    .addrCnt    (addrCnt),
    .bitCnt     (bitCnt),
    .strobe     (strobe)
  );

  boot_ld_datapath #(
    .IMAGE_BYTES(IMAGE_BYTES), .MBOX_W(MBOX_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .hostWrData  (hostWrData),
    .coproWrEn   (coproWrEn),
    .coproWrData (coproWrData),
    .addrCnt     (addrCnt),
    .bitCnt      (bitCnt),
    .coproCmd    (coproCmd),
    .hostStatus  (hostStatus),
    .fastIrq     (fastIrq),
    .coproReset  (coproReset),
    .ramWrEn     (ramWrEn),
    .ramWrAddr   (ramWrAddr),
    .ramWrData   (ramWrData)
  );
endmodule

// File: rtl/boot_ld_chk.sv
module boot_ld_chk #(
  parameter int RAM_AW      = 8,
  parameter int IMAGE_BYTES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hostWrEn,
  input logic [7:0]        hostWrData,
  input logic [7:0]        hostStatus,
  input logic              coproWrEn,
  input logic [7:0]        coproCmd,
  input logic              fastIrq,
  input logic              coproReset,
  input logic              ramWrEn,
  input logic [RAM_AW-1:0] ramWrAddr
);
  AST_IRQ_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    hostWrEn |=> fastIrq);                                              // R6
  AST_CMD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    hostWrEn |=> (coproCmd == $past(hostWrData)));                      // R6
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (coproWrEn && !hostWrEn) |=> !fastIrq);                             // R7
  AST_RESET_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && hostWrData[1]) |=> coproReset);                        // R1
  AST_NO_TOGGLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && (hostWrData[7] == coproCmd[7])) |=> !ramWrEn);         // R2
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrEn |=> !ramWrEn);                                              // R3
  AST_RELEASE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coproReset) |-> (ramWrEn && ramWrAddr == RAM_AW'(IMAGE_BYTES - 1))); // R4
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hostStatus[0]) |-> ($past(hostWrEn) || $past(coproWrEn)));   // R5
endmodule

bind copro_boot_loader boot_ld_chk #(.RAM_AW(RAM_AW), .IMAGE_BYTES(IMAGE_BYTES)) u_chk (.*);

// File: tb/sim_copro_boot_loader.sv
module sim_copro_boot_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       coproWrEn = 1'b0;
  logic [7:0] coproWrData = '0;
  logic [7:0] hostStatus, coproCmd, ramWrData, ramWrAddr;
  logic       fastIrq, coproReset, ramWrEn;

  int checks = 0;
  int errors = 0;
  int expAddr = 0;
  logic tgl = 1'b0;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;

  copro_boot_loader u0 (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostStatus(hostStatus), .coproWrEn(coproWrEn), .coproWrData(coproWrData),
    .coproCmd(coproCmd), .fastIrq(fastIrq), .coproReset(coproReset),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic coproWrite(input logic [7:0] d);
    @(negedge clk);
    coproWrEn = 1'b1; coproWrData = d;
    @(negedge clk);
    coproWrEn = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    tgl = ~tgl;
    hostWrite({tgl, 5'b0, 1'b0, b});
  endtask

  task automatic sendByte(input logic [7:0] v, input bit expectWrite);
    if (expectWrite) begin
      expQ.push_back({8'(expAddr), v});
      expAddr++;
    end
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  // Scoreboard monitor: every RAM write must match the next expected item (R3)
  always @(negedge clk) begin
    if (rst_n && ramWrEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected write got %h:%h exp none", ramWrAddr, ramWrData);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        if ({ramWrAddr, ramWrData} !== e) begin
          errors++;
          $display("FAIL R3 ram write got %h exp %h", {ramWrAddr, ramWrData}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog got running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R8 reset state
    check("R8 coproReset", 16'(coproReset), 16'h1);
    check("R8 fastIrq", 16'(fastIrq), 16'h0);
    check("R8 hostStatus", 16'(hostStatus), 16'h0);
    check("R8 coproCmd", 16'(coproCmd), 16'h0);

    // R1/R6: reset request without toggle
    hostWrite(8'h02);
    check("R1 coproReset", 16'(coproReset), 16'h1);
    check("R6 fastIrq", 16'(fastIrq), 16'h1);
    check("R6 coproCmd", 16'(coproCmd), 16'h02);
    check("R2 no busy without toggle", 16'(hostStatus), 16'h0);

    // R7: coprocessor write clears interrupt
    coproWrite(8'h00);
    check("R7 fastIrq low", 16'(fastIrq), 16'h0);

    // R3/R5: first byte, busy window edges
    sendByte(8'h80, 1'b1);
    check("R5 busy set", 16'(hostStatus[0]), 16'h1);
    idle(749);
    check("R5 busy still set", 16'(hostStatus[0]), 16'h1);
    idle(1);
    check("R5 busy cleared", 16'(hostStatus[0]), 16'h0);

    // R9: restart of busy window
    sendByte(8'h01, 1'b1);
    idle(400);
    sendByte(8'h02, 1'b1);
    idle(400);
    check("R9 busy restarted", 16'(hostStatus[0]), 16'h1);
    idle(350);
    check("R9 busy cleared after restart", 16'(hostStatus[0]), 16'h0);

    // R2: command without toggle is ignored
    hostWrite({tgl, 5'b0, 1'b0, 1'b1});
    idle(10);
    check("R2 no busy", 16'(hostStatus[0]), 16'h0);
    sendByte(8'hA5, 1'b1);
    idle(760);

    // R7/R5: status replacement, busy bit only touches bit 0
    coproWrite(8'h5A);
    check("R7 status replaced", 16'(hostStatus), 16'h5A);
    expQ.push_back({8'(expAddr), 8'hC3});
    expAddr++;
    sendBit(1'b1);
    check("R5 busy bit only", 16'(hostStatus), 16'h5B);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    idle(760);
    check("R5 status restored", 16'(hostStatus), 16'h5A);

    // R10/R1: toggling reset request delivers a bit at address 0
    expAddr = 0;
    expQ.push_back({8'(expAddr), 8'hB3});
    expAddr++;
    tgl = ~tgl;
    hostWrite({tgl, 5'b0, 1'b1, 1'b1});
    check("R1 reset asserted", 16'(coproReset), 16'h1);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);

    // R4: full image
    for (int a = 1; a < 255; a++) sendByte(8'(a) ^ 8'h3C, 1'b1);
    check("R4 held before last byte", 16'(coproReset), 16'h1);
    sendByte(8'hFF ^ 8'h3C, 1'b1);
    check("R4 released", 16'(coproReset), 16'h0);
    idle(760);
    sendByte(8'h77, 1'b0);
    idle(2);
    check("R4 no busy after image", 16'(hostStatus), 16'h5A);
    check("R4 stays released", 16'(coproReset), 16'h0);
    check("R6 irq after image", 16'(fastIrq), 16'h1);
    check("R3 all writes seen", 16'(expQ.size()), 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule